// File: doc/BRIEF.md
# Serial Bus Master with Busy/Ready Handshake

This block is the master-side sequencer of a two-wire synchronous serial bus. It drives the serial clock (SCK) and shares an open-drain data line with one or more slaves. A start strobe launches one byte. The master shifts the byte out MSB first. It then frees the line for the acknowledge clock. After that it keeps SCK running while it checks the line on every SCK falling edge. A slave that needs time holds the line low, which is the busy indication.

When the slave lets the line return high, the master ends the clock with no outside action. SCK finishes its current low half and then rests high. A one-cycle completion pulse follows. A new byte is accepted only when the controller is idle and the line reads high (ready). A busy level that lasts too many SCK periods is cut off by a timeout, which flags an error. A start strobe that cannot be honoured is dropped and flagged.

Top module: `sbm_busy_master`

## Requirements
- R1: After reset, sck_o is high, sda_oe_o, busy_o, done_o, err_start_o and err_timeout_o are low, and ready_o follows the line (high when nothing pulls it low).
- R2: SCK rests high whenever no transfer runs. While running, each SCK half (low and high) lasts exactly HALF_DIV system clocks.
- R3: The byte goes out MSB first, one bit per SCK period. sda_oe_o=1 drives a 0 bit and sda_oe_o=0 lets the line float high for a 1 bit. The bit changes only at SCK falling edges, so it is stable across each rising edge.
- R4: During the ninth SCK period (the acknowledge position) the master keeps sda_oe_o low.
- R5: Starting from the eleventh SCK falling edge, the master samples the line at each falling edge. A low sample sets busy_o.
- R6: The first high sample ends the transfer. SCK rises once more and then stays high, done_o pulses for exactly one cycle, and busy_o is low. The number of falling edges is 11 plus the number of busy samples.
- R7: If the first sample (the eleventh falling edge) is high, the transfer ends after exactly 11 falling edges and busy_o never rises.
- R8: If the line is low on BUSY_LIMIT consecutive samples, err_timeout_o is set and busy_o is cleared. The clock stops as in R6 after 10+BUSY_LIMIT falling edges.
- R9: A start strobe that arrives while a transfer, busy phase or clock wind-down is in progress does not disturb it, and it sets err_start_o.
- R10: A start strobe in idle while the line reads low produces no SCK activity and sets err_start_o.
- R11: ready_o is high exactly when the controller is idle and the line reads high.
- R12: An accepted start clears err_start_o and err_timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a byte |
| tx_data_i | input | DATA_BITS | Byte to send, sampled with an accepted start |
| sda_i | input | 1 | Resolved level of the shared data line |
| sda_oe_o | output | 1 | Drive-low enable for the data line |
| sck_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Slave reported busy on the last sample |
| ready_o | output | 1 | Idle and line high; a new start will be taken |
| done_o | output | 1 | One-cycle pulse when the clock has stopped |
| err_start_o | output | 1 | Sticky: a start strobe was refused |
| err_timeout_o | output | 1 | Sticky: busy outlasted BUSY_LIMIT samples |

## Verification
Two functions can act on the same falling-edge sample: the decision to keep clocking on a low busy level, and the timeout that ends the busy phase. The bench sets them against each other by holding the line low for BUSY_LIMIT-1 samples and then for exactly BUSY_LIMIT samples. Both runs end after the same number of falling edges. The scoreboard tells them apart by the timeout flag and by busy_o, which must be low at completion in both. A start strobe fired mid-transfer is also checked, by comparing the byte and edge count of the transfer it overlapped against the expected values.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WATCH = 2'd2,
        ST_STOP  = 2'd3
    } sbm_state_e;
endpackage

// File: rtl/sbm_sck_gen.sv
module sbm_sck_gen #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tog;

    assign tog    = run_i && (gen_q.cnt == CW'(HALF_DIV - 1));
    assign fall_o = tog && gen_q.sck;
    assign rise_o = tog && !gen_q.sck;
    assign sck_o  = gen_q.sck;

    always_comb begin
        gen_d = gen_q;
        if (!run_i) begin
            gen_d.cnt = '0;
            gen_d.sck = 1'b1;
        end else if (tog) begin
            gen_d.cnt = '0;
            gen_d.sck = !gen_q.sck;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.cnt <= '0;
            gen_q.sck <= 1'b1;
        end else begin
            gen_q <= gen_d;
        end
    end

    // R2: a stopped generator leaves SCK high on the following cycle
    assert_rest_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> sck_o);
endmodule

// File: rtl/sbm_busy_timer.sv
module sbm_busy_timer #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire_o = inc_i && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R8: the busy count never runs past the limit
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/sbm_busy_master.sv
module sbm_busy_master
    import sbm_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int HALF_DIV   = 3,
    parameter int BUSY_LIMIT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] tx_data_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    output logic                 sck_o,
    output logic                 busy_o,
    output logic                 ready_o,
    output logic                 done_o,
    output logic                 err_start_o,
    output logic                 err_timeout_o
);
    localparam int ACK_FALL   = DATA_BITS + 1;
    localparam int WATCH_FALL = DATA_BITS + 2;
    localparam int FW         = $clog2(WATCH_FALL + 1);

    typedef struct packed {
        sbm_state_e          st;
        logic [FW-1:0]       fcnt;
        logic [DATA_BITS-1:0] shreg;
        logic                oe;
        logic                run;
        logic                busy;
        logic                done;
        logic                err_start;
        logic                err_to;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic sck_fall, sck_rise, accept, tmr_inc, tmr_expire;
    logic [FW-1:0] nf;

    sbm_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (ctl_q.run),
        .sck_o (sck_o),
        .fall_o(sck_fall),
        .rise_o(sck_rise)
    );

    assign accept  = (ctl_q.st == ST_IDLE) && start_i && sda_i;
    assign tmr_inc = (ctl_q.st == ST_WATCH) && sck_fall && !sda_i;

    sbm_busy_timer #(.LIMIT(BUSY_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .inc_i   (tmr_inc),
        .expire_o(tmr_expire)
    );

    assign nf = ctl_q.fcnt + 1'b1;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (sda_i) begin
                        ctl_d.st        = ST_XFER;
                        ctl_d.fcnt      = '0;
                        ctl_d.shreg     = tx_data_i;
                        ctl_d.oe        = !tx_data_i[DATA_BITS-1];
                        ctl_d.run       = 1'b1;
                        ctl_d.err_start = 1'b0;
                        ctl_d.err_to    = 1'b0;
                    end else begin
                        ctl_d.err_start = 1'b1;
                    end
                end
            end
            ST_XFER: begin
                if (start_i) ctl_d.err_start = 1'b1;
                if (sck_fall) begin
                    ctl_d.fcnt = nf;
                    if (nf >= FW'(2) && nf <= FW'(DATA_BITS)) begin
                        ctl_d.shreg = {ctl_q.shreg[DATA_BITS-2:0], 1'b0};
                        ctl_d.oe    = !ctl_q.shreg[DATA_BITS-2];
                    end
                    if (nf == FW'(ACK_FALL)) ctl_d.oe = 1'b0;
                    if (nf == FW'(WATCH_FALL)) ctl_d.st = ST_WATCH;
                end
            end
            ST_WATCH: begin
                if (start_i) ctl_d.err_start = 1'b1;
                if (sck_fall) begin
                    if (!sda_i) begin
                        if (tmr_expire) begin
                            ctl_d.err_to = 1'b1;
                            ctl_d.busy   = 1'b0;
                            ctl_d.st     = ST_STOP;
                        end else begin
                            ctl_d.busy = 1'b1;
                        end
                    end else begin
                        ctl_d.busy = 1'b0;
                        ctl_d.st   = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (start_i) ctl_d.err_start = 1'b1;
                if (sck_rise) begin
                    ctl_d.run  = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.fcnt      <= '0;
            ctl_q.shreg     <= '0;
            ctl_q.oe        <= 1'b0;
            ctl_q.run       <= 1'b0;
            ctl_q.busy      <= 1'b0;
            ctl_q.done      <= 1'b0;
            ctl_q.err_start <= 1'b0;
            ctl_q.err_to    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o      = ctl_q.oe;
    assign busy_o        = ctl_q.busy;
    assign done_o        = ctl_q.done;
    assign err_start_o   = ctl_q.err_start;
    assign err_timeout_o = ctl_q.err_to;
    assign ready_o       = (ctl_q.st == ST_IDLE) && sda_i;

    assert_idle_sck_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> sck_o);
    assert_drive_only_in_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (ctl_q.st == ST_XFER));
    assert_busy_only_watching_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctl_q.st == ST_WATCH));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_timeout_drops_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout_o |-> !busy_o);
    assert_late_start_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st != ST_IDLE) && start_i) |=> err_start_o);
endmodule

// File: tb/sbm_busy_master_tb.sv
module sbm_busy_master_tb;
    localparam int DW   = 8;
    localparam int HALF = 3;
    localparam int LIM  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] tx = '0;
    logic slv_low = 1'b0;
    logic sda;
    logic oe, sck, busy, ready, done, e_start, e_to;

    always #2 clk = ~clk;

    assign sda = !(oe || slv_low);

    sbm_busy_master #(.DATA_BITS(DW), .HALF_DIV(HALF), .BUSY_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tx_data_i(tx), .sda_i(sda),
        .sda_oe_o(oe), .sck_o(sck), .busy_o(busy), .ready_o(ready), .done_o(done),
        .err_start_o(e_start), .err_timeout_o(e_to)
    );

    typedef struct {
        logic [DW-1:0] d;
        int            falls;
        logic          to;
        logic          bsy;
    } exp_t;
    exp_t sb_q[$];

    int nvec = 0, nerr = 0;
    int falls = 0, rises = 0, lowcnt = 0, lowlen = 0, slv_b = 0;
    logic [DW-1:0] cap = '0;
    logic bsy_seen = 1'b0;
    logic prev_sck = 1'b1;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor + slave model
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sck && !sck) begin
                falls++;
                if (falls == DW + 1) slv_low = 1'b1;
                else if (falls >= DW + 2) slv_low = (falls < DW + 2 + slv_b);
            end
            if (!prev_sck && sck) begin
                rises++;
                if (rises <= DW) cap = {cap[DW-2:0], sda};
                if (rises == DW + 1) chk(oe == 1'b0, "R4 ack release", int'(oe), 0);
                lowlen = lowcnt;
                lowcnt = 0;
            end
            if (!sck) lowcnt++;
            if (busy) bsy_seen = 1'b1;
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(cap == e.d, "R3 byte", int'(cap), int'(e.d));
                    chk(falls == e.falls, "R6/R7/R8 falling edges", falls, e.falls);
                    chk(e_to == e.to, "R8 timeout flag", int'(e_to), int'(e.to));
                    chk(bsy_seen == e.bsy, "R5 busy seen", int'(bsy_seen), int'(e.bsy));
                    chk(busy == 1'b0, "R6 busy low at done", int'(busy), 0);
                    chk(lowlen == HALF, "R2 half period", lowlen, HALF);
                end
            end
        end
        prev_sck = sck;
    end

    task automatic xfer(input logic [DW-1:0] d, input int b, input bit poke, input bit chk_clr);
        exp_t e;
        @(negedge clk);
        falls = 0; rises = 0; cap = '0; bsy_seen = 1'b0; slv_b = b;
        tx = d; start = 1'b1;
        e.d = d;
        e.falls = (b >= LIM) ? (DW + 2 + LIM) : (DW + 3 + b);
        e.to = (b >= LIM);
        e.bsy = (b > 0);
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (chk_clr) begin
            chk(e_start == 1'b0, "R12 start error cleared", int'(e_start), 0);
            chk(e_to == 1'b0, "R12 timeout error cleared", int'(e_to), 0);
        end
        if (poke) begin
            repeat (20) @(negedge clk);
            tx = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(e_start == 1'b1, "R9 late start flagged", int'(e_start), 1);
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sck == 1'b1, "R1 sck high", int'(sck), 1);
        chk(oe == 1'b0, "R1 oe low", int'(oe), 0);
        chk((busy | done | e_start | e_to) == 1'b0, "R1 flags clear",
            int'({busy, done, e_start, e_to}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ready == 1'b1, "R1 R11 ready at rest", int'(ready), 1);

        xfer(8'hA5, 0, 1'b0, 1'b0);   // R7 no busy
        xfer(8'h3C, 3, 1'b1, 1'b0);   // R5 R6 busy + R9 poke
        xfer(8'h00, 1, 1'b0, 1'b1);   // R12 clears the start error
        xfer(8'hFF, LIM - 1, 1'b0, 1'b0); // longest busy without timeout
        xfer(8'h5A, LIM, 1'b0, 1'b0); // R8 timeout boundary
        chk(busy == 1'b0, "R8 busy cleared", int'(busy), 0);
        xfer(8'hC3, LIM + 2, 1'b0, 1'b0); // R8 timeout, slave stays low
        chk(ready == 1'b0, "R11 not ready while line low", int'(ready), 0);

        // R10: start refused while line low
        falls = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(e_start == 1'b1, "R10 refused start flagged", int'(e_start), 1);
        repeat (12) @(negedge clk);
        chk(falls == 0, "R10 no SCK activity", falls, 0);
        chk(sck == 1'b1, "R2 R10 sck rests high", int'(sck), 1);

        slv_low = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R11 ready after release", int'(ready), 1);
        xfer(8'h96, 2, 1'b0, 1'b1);   // R12 both flags cleared

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule